// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port run by software through a two-location register interface. Once it has eight bits to move, it generates its own shift clock on an output pin and moves those bits over a single bidirectional data line. In transmit, the data line is driven by the port. In receive, an external device drives the line and the port samples it. The data pin has no open-drain driver, so the port drives an explicit output enable that is high only while it transmits.

Software starts a transmission by writing a byte to the data location. It starts a reception by setting the receive-enable control bit while the receive-complete flag is clear. A rate-select control bit picks a bit period of 12 system clocks or 4 system clocks. The rate is captured when a transfer starts. Completion flags for each direction are set by hardware and cleared by software. A flag cannot be set by a software write.

Top module: `ssp_port`

## Requirements
- R1: With the rate-select bit (control bit 1) at 0, each bit period lasts 12 system clocks. The shift clock is low for the first 6 clocks and high for the last 6.
- R2: With the rate-select bit at 1, each bit period lasts 4 system clocks. The shift clock is low for 2 clocks and high for 2 clocks.
- R3: A write to address 0 while the port is idle starts a transmission in the next cycle. The data-line output enable is high for the whole transmission.
- R4: Transmitted bits leave least significant bit first, one per bit period. The data output changes only while the shift clock is low.
- R5: A transfer is exactly eight bit periods long. A transmission sets the transmit-complete flag (control bit 2) at the edge that ends the eighth period, so the whole transfer takes 8 times the bit period from the write edge. The shift clock is then high and the output enable is low.
- R6: A write to address 0 during a transfer is ignored. No extra transfer follows, and the byte being sent is unchanged.
- R7: Writing 0 to a flag bit in the control location (address 1) clears that flag, and writing 1 leaves it unchanged. When hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R8: While the port is idle, receive-enable (control bit 0) at 1 with the receive-complete flag at 0 starts a reception. The output enable stays low throughout the reception.
- R9: During reception, the data input is sampled at each rising edge of the shift clock, least significant bit first. The received byte can be read at address 0.
- R10: Reception sets the receive-complete flag (control bit 3) at the end of the eighth bit period. No new reception starts while this flag is 1.
- R11: Synchronous active-high reset clears both flags, receive-enable and rate-select, and aborts any transfer. After reset the shift clock idles high and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 data, 1 control |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for the selected register (combinational) |
| sclk_o | output | 1 | Shift clock driven by the port, idles high |
| sdat_o | output | 1 | Data line output value |
| sdat_oe | output | 1 | Data line output enable |
| sdat_i | input | 1 | Data line input value |

## Verification
A software write that clears the receive-complete flag can reach the control location in the same cycle that the eighth bit period of a reception ends and hardware sets that flag. The bench provokes this in the fast rate. It counts rising shift-clock edges at the pin, and after the eighth rise it times its clearing write so that it is sampled exactly at the ending edge. It then judges the collision by reading the control location: the flag must still be set, and the received byte must be intact.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   // register select values
   localparam logic ADDR_DATA = 1'b0;
   localparam logic ADDR_CTRL = 1'b1;

   // control location bit positions
   localparam int CB_RXEN   = 0;
   localparam int CB_FAST   = 1;
   localparam int CB_TXDONE = 2;
   localparam int CB_RXDONE = 3;
   localparam int CTRL_BITS = 4;

   typedef enum logic [1:0] {
      XF_IDLE = 2'd0,
      XF_TX   = 2'd1,
      XF_RX   = 2'd2
   } xfer_e;

endpackage

// File: rtl/ssp_timer.sv
module ssp_timer #(
   parameter int SLOW_DIV = 12,
   parameter int FAST_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic fast_i,
   input  logic run,
   output logic sclk_low,
   output logic rise,
   output logic bit_end
);

   localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
   localparam int CW     = $clog2(MAXDIV);

   generate
      if (SLOW_DIV < 2 || (SLOW_DIV % 2) != 0) begin : g_bad_slow
         $error("ssp_timer: SLOW_DIV must be even and at least 2");
      end
      if (FAST_DIV < 2 || (FAST_DIV % 2) != 0) begin : g_bad_fast
         $error("ssp_timer: FAST_DIV must be even and at least 2");
      end
   endgenerate

   logic          fast_q;
   logic [CW-1:0] cnt;
   logic [CW-1:0] per_m1;
   logic [CW-1:0] half;

   always_comb begin
      per_m1 = fast_q ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
      half   = fast_q ? CW'(FAST_DIV / 2) : CW'(SLOW_DIV / 2);
   end

   // rate is frozen for the whole transfer
   always_ff @(posedge clk) begin
      if (rst)        fast_q <= 1'b0;
      else if (start) fast_q <= fast_i;
   end

   always_ff @(posedge clk) begin
      if (rst || start || !run) cnt <= '0;
      else if (cnt == per_m1)   cnt <= '0;
      else                      cnt <= cnt + CW'(1);
   end

   assign sclk_low = run && (cnt < half);
   assign rise     = run && (cnt == (half - CW'(1)));
   assign bit_end  = run && (cnt == per_m1);

   // R1 R2: phase counter never leaves the selected period
   p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
      run |-> cnt <= per_m1);
   // R1 R2: the sample strobe is followed by the high half of the period
   p_high_after_rise_r2: assert property (@(posedge clk) disable iff (rst)
      (rise && run) |=> (!sclk_low || !run));

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter import ssp_pkg::*; #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_tx,
   input  logic          req_rx,
   input  logic [DW-1:0] tx_data,
   input  logic          sdat_i,
   input  logic          rise,
   input  logic          bit_end,
   output logic          busy,
   output logic          tx_mode,
   output logic          done_tx,
   output logic          done_rx,
   output logic          sdat_o,
   output logic [DW-1:0] rx_word
);

   localparam int BW = $clog2(DW);

   xfer_e         mode;
   logic [DW-1:0] sh;
   logic [BW-1:0] bitn;
   logic          last;

   assign last = (bitn == BW'(DW - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         mode <= XF_IDLE;
         sh   <= '0;
         bitn <= '0;
      end else if (mode == XF_IDLE) begin
         bitn <= '0;
         if (req_tx) begin
            mode <= XF_TX;
            sh   <= tx_data;
         end else if (req_rx) begin
            mode <= XF_RX;
         end
      end else begin
         if (rise && mode == XF_RX)
            sh <= {sdat_i, sh[DW-1:1]};
         if (bit_end) begin
            if (mode == XF_TX)
               sh <= {1'b0, sh[DW-1:1]};
            if (last) mode <= XF_IDLE;
            else      bitn <= bitn + BW'(1);
         end
      end
   end

   assign busy    = (mode != XF_IDLE);
   assign tx_mode = (mode == XF_TX);
   assign done_tx = bit_end && last && (mode == XF_TX);
   assign done_rx = bit_end && last && (mode == XF_RX);
   assign sdat_o  = sh[0];
   assign rx_word = sh;

   // R6: a load request during a transfer disturbs neither mode nor bit index
   p_busy_load_ignored_r6: assert property (@(posedge clk) disable iff (rst)
      (busy && req_tx && !bit_end) |=> (mode == $past(mode) && bitn == $past(bitn)));
   // R5: a transfer never ends before its final bit
   p_end_on_last_r5: assert property (@(posedge clk) disable iff (rst)
      (busy && bit_end && !last) |=> busy);

endmodule

// File: rtl/ssp_port.sv
module ssp_port import ssp_pkg::*; #(
   parameter int DW       = 8,
   parameter int SLOW_DIV = 12,
   parameter int FAST_DIV = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          reg_wr,
   input  logic          reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          sclk_o,
   output logic          sdat_o,
   output logic          sdat_oe,
   input  logic          sdat_i
);

   generate
      if (DW < CTRL_BITS) begin : g_bad_dw
         $error("ssp_port: DW must hold the control bits");
      end
   endgenerate

   logic          rx_en, fast, tx_done, rx_done;
   logic [DW-1:0] rx_buf;
   logic          wr_data, wr_ctrl, req_rx, start_any;
   logic          busy, tx_mode, done_tx, done_rx;
   logic          sclk_low, rise, bit_end;
   logic [DW-1:0] rx_word;
   logic [CTRL_BITS-1:0] ctrl_view;

   assign wr_data   = reg_wr && (reg_addr == ADDR_DATA);
   assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
   assign req_rx    = rx_en && !rx_done;
   assign start_any = !busy && (wr_data || req_rx);

   ssp_timer #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .start    (start_any),
      .fast_i   (fast),
      .run      (busy),
      .sclk_low (sclk_low),
      .rise     (rise),
      .bit_end  (bit_end)
   );

   ssp_shifter #(.DW(DW)) u_shift (
      .clk     (clk),
      .rst     (rst),
      .req_tx  (wr_data),
      .req_rx  (req_rx),
      .tx_data (reg_wdata),
      .sdat_i  (sdat_i),
      .rise    (rise),
      .bit_end (bit_end),
      .busy    (busy),
      .tx_mode (tx_mode),
      .done_tx (done_tx),
      .done_rx (done_rx),
      .sdat_o  (sdat_o),
      .rx_word (rx_word)
   );

   // control bits and flags; hardware set outranks a software clear
   always_ff @(posedge clk) begin
      if (rst) begin
         rx_en   <= 1'b0;
         fast    <= 1'b0;
         tx_done <= 1'b0;
         rx_done <= 1'b0;
         rx_buf  <= '0;
      end else begin
         if (wr_ctrl) begin
            rx_en <= reg_wdata[CB_RXEN];
            fast  <= reg_wdata[CB_FAST];
         end
         if (done_tx)                             tx_done <= 1'b1;
         else if (wr_ctrl && !reg_wdata[CB_TXDONE]) tx_done <= 1'b0;
         if (done_rx)                             rx_done <= 1'b1;
         else if (wr_ctrl && !reg_wdata[CB_RXDONE]) rx_done <= 1'b0;
         if (done_rx) rx_buf <= rx_word;
      end
   end

   always_comb begin
      ctrl_view            = '0;
      ctrl_view[CB_RXEN]   = rx_en;
      ctrl_view[CB_FAST]   = fast;
      ctrl_view[CB_TXDONE] = tx_done;
      ctrl_view[CB_RXDONE] = rx_done;
   end

   generate
      if (DW > CTRL_BITS) begin : g_rd_wide
         assign reg_rdata = (reg_addr == ADDR_CTRL)
                            ? {{(DW-CTRL_BITS){1'b0}}, ctrl_view} : rx_buf;
      end else begin : g_rd_exact
         assign reg_rdata = (reg_addr == ADDR_CTRL) ? ctrl_view : rx_buf;
      end
   endgenerate

   assign sclk_o  = !sclk_low;
   assign sdat_oe = tx_mode;

   // R11: shift clock rests high whenever no transfer runs
   p_idle_high_r11: assert property (@(posedge clk) disable iff (rst)
      !busy |-> sclk_o);
   // R4: driven data only moves while the shift clock is low
   p_data_moves_low_r4: assert property (@(posedge clk) disable iff (rst)
      (sdat_oe && $past(sdat_oe) && sdat_o != $past(sdat_o)) |-> !sclk_o);
   // R5: transmit flag rises only out of a running transmission
   p_txdone_source_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_done) |-> $past(busy && tx_mode));
   // R10: no reception runs while its completion flag is up
   p_no_rx_with_flag_r10: assert property (@(posedge clk) disable iff (rst)
      rx_done |-> !(busy && !tx_mode));
   // R7: a completing reception always leaves the flag set
   p_hw_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      done_rx |=> rx_done);

endmodule

// File: tb/ssp_port_tb.sv
module ssp_port_tb;
   import ssp_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       reg_wr = 1'b0;
   logic       reg_addr = ADDR_CTRL;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       sclk_o, sdat_o, sdat_oe;
   logic       sdat_i = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [7:0] exp_q[$];
   int         exp_half = 6;
   int         tx_seen = 0;
   logic [7:0] rx_pat = '0;
   int         rx_idx = 0;
   int         p_falls = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ssp_port u_dut (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o),
      .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = ADDR_CTRL;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
      reg_addr = ADDR_CTRL;
      #1;
   endtask

   // monitor: rebuilds transmitted bytes at the pins and scores them
   initial begin
      logic       prev = 1'b1;
      int         low_len = 0;
      int         mbits = 0;
      logic [7:0] mbyte = '0;
      forever begin
         @(negedge clk);
         if (rst) begin
            prev = 1'b1; low_len = 0; mbits = 0;
         end else begin
            if (sclk_o && !prev) begin
               chk(low_len == exp_half, exp_half == 6 ? "R1 low phase" : "R2 low phase",
                   low_len, exp_half);
               if (sdat_oe) begin
                  mbyte = {sdat_o, mbyte[7:1]};
                  mbits++;
                  if (mbits == 8) begin
                     mbits = 0;
                     tx_seen++;
                     if (exp_q.size() == 0)
                        chk(1'b0, "R6 unexpected transfer", mbyte, 0);
                     else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(mbyte == e, "R4 tx byte LSB first", mbyte, e);
                     end
                  end
               end
               low_len = 0;
            end
            if (!sclk_o) low_len++;
            prev = sclk_o;
         end
      end
   end

   // peer device: puts the next receive bit on the line at each falling shift clock
   initial begin
      logic prev = 1'b1;
      forever begin
         @(negedge clk);
         if (rst) prev = 1'b1;
         else begin
            if (!sclk_o && prev) begin
               p_falls++;
               if (!sdat_oe && rx_idx < 8) begin
                  sdat_i = rx_pat[rx_idx];
                  rx_idx++;
               end
            end
            prev = sclk_o;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      logic [7:0] v;
      int k;
      int seen0;
      int falls0;
      bit oe_bad;
      logic prv;
      int rises;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R11: reset state at the pins and in the control location
      chk(sclk_o == 1'b1, "R11 sclk idle", sclk_o, 1);
      chk(sdat_oe == 1'b0, "R11 oe low", sdat_oe, 0);
      rd(ADDR_CTRL, v);
      chk(v == 8'h00, "R11 control cleared", v, 0);

      // R1 R3 R5: slow transmission and its length
      exp_half = 6;
      exp_q.push_back(8'hA5);
      wr(ADDR_DATA, 8'hA5);
      chk(sdat_oe == 1'b1, "R3 oe during tx", sdat_oe, 1);
      k = 1;
      rd(ADDR_CTRL, v);
      while (!v[CB_TXDONE] && k < 1000) begin
         @(negedge clk); k++; rd(ADDR_CTRL, v);
      end
      chk(k == 97, "R5 R1 slow transfer length", k, 97);
      chk(sclk_o == 1'b1 && sdat_oe == 1'b0, "R5 pins after tx", {sclk_o, sdat_oe}, 2'b10);

      // R7: writing 1 keeps the flag, writing 0 clears it
      wr(ADDR_CTRL, 8'h04);
      rd(ADDR_CTRL, v);
      chk(v[CB_TXDONE] == 1'b1, "R7 write one keeps flag", v, 8'h04);
      wr(ADDR_CTRL, 8'h02);
      rd(ADDR_CTRL, v);
      chk(v == 8'h02, "R7 write zero clears flag", v, 8'h02);

      // R2: fast transmission length
      exp_half = 2;
      exp_q.push_back(8'h3C);
      wr(ADDR_DATA, 8'h3C);
      k = 1;
      rd(ADDR_CTRL, v);
      while (!v[CB_TXDONE] && k < 1000) begin
         @(negedge clk); k++; rd(ADDR_CTRL, v);
      end
      chk(k == 33, "R2 fast transfer length", k, 33);

      // R6: second write during a transfer is dropped
      seen0 = tx_seen;
      exp_q.push_back(8'h81);
      wr(ADDR_DATA, 8'h81);
      repeat (5) @(negedge clk);
      wr(ADDR_DATA, 8'h7E);
      repeat (80) @(negedge clk);
      chk(tx_seen == seen0 + 1, "R6 one transfer only", tx_seen - seen0, 1);
      chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

      // R8 R9 R10: slow reception
      exp_half = 6;
      rx_pat = 8'h96; rx_idx = 0;
      wr(ADDR_CTRL, 8'h01);
      oe_bad = 0; k = 0;
      rd(ADDR_CTRL, v);
      while (!v[CB_RXDONE] && k < 1000) begin
         @(negedge clk); k++;
         if (sdat_oe) oe_bad = 1;
         rd(ADDR_CTRL, v);
      end
      chk(oe_bad == 0, "R8 oe stays low in rx", oe_bad, 0);
      chk(v[CB_RXDONE] == 1'b1, "R10 rx flag set", v, 8'h09);
      rd(ADDR_DATA, v);
      chk(v == 8'h96, "R9 received byte", v, 8'h96);
      falls0 = p_falls;
      repeat (50) @(negedge clk);
      #1;
      chk(p_falls == falls0, "R10 no rx while flag set", p_falls - falls0, 0);

      // R7 R2 R9: fast reception, clear lands on the setting edge
      exp_half = 2;
      rx_pat = 8'h4B; rx_idx = 0;
      wr(ADDR_CTRL, 8'h03);
      prv = 1'b1; rises = 0; k = 0;
      while (rises < 8 && k < 1000) begin
         @(negedge clk); k++;
         if (sclk_o && !prv) rises++;
         prv = sclk_o;
      end
      wr(ADDR_CTRL, 8'h03);
      rd(ADDR_CTRL, v);
      chk(v[CB_RXDONE] == 1'b1, "R7 hardware set wins", v, 8'h0B);
      rd(ADDR_DATA, v);
      chk(v == 8'h4B, "R9 fast received byte", v, 8'h4B);
      wr(ADDR_CTRL, 8'h00);

      // R11: reset aborts a running transmission
      exp_half = 6;
      wr(ADDR_DATA, 8'h55);
      repeat (30) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(sclk_o == 1'b1 && sdat_oe == 1'b0, "R11 abort pins", {sclk_o, sdat_oe}, 2'b10);
      repeat (100) @(negedge clk);
      rd(ADDR_CTRL, v);
      chk(v == 8'h00, "R11 no flag after abort", v, 0);
      chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);

      summary();
   end

endmodule